// File: doc/BRIEF.md
# BCD Calendar Timekeeping Register File

This block is the counting core of a real-time clock. It keeps seconds, minutes, hours, day of month, month and a two-digit year in packed BCD, plus a weekday as a small binary count. The years run from 2000 to 2099, and leap years in that span are handled. A one-hertz strobe from an external prescaler advances the time by one second. The block puts out a hold signal that keeps that prescaler cleared while the clock is halted.

Software reaches the core through a flat byte-wide register port. A write is one clock cycle with the write enable high. A read is combinational on the address. An access-busy input marks a multi-byte transaction. For as long as it is high the counters stay frozen, so that every byte read belongs to the same instant. A second that ends during the transaction is held and applied once the transaction closes.

The control byte has a halt bit that stops the counters, and a command code that returns every register to its power-on value. Bit 7 of the seconds byte is a sticky flag meaning "time not trustworthy". A general-purpose scratch byte is also provided.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the registers read as follows: 0x04 (seconds) = 0x80, 0x05 (minutes) = 0x00, 0x06 (hours) = 0x00, 0x07 (day) = 0x01, 0x08 (weekday) = 0x00, 0x09 (month) = 0x01, 0x0A (year) = 0x00, 0x00 (control) = 0x00, 0x01 (second control byte) = 0x00, 0x03 (scratch) = 0x00. `presc_hold` is 0.
- R2: Each `sec_tick` pulse advances the seconds by one in BCD. Seconds wrap from 0x59 to 0x00 and carry into minutes. Minutes wrap from 0x59 to 0x00 and carry into hours. Hours wrap from 0x23 to 0x00 and carry into the date.
- R3: On a carry out of the hours, the day of month wraps to 0x01 after the last day of the current month. That last day is 30 for months 0x04, 0x06, 0x09 and 0x11, and 31 for the other months except February. February ends on day 29 when the BCD year is divisible by 4, counting 00 as such a year, and on day 28 otherwise.
- R4: A carry out of the day advances the month, which wraps from 0x12 to 0x01. A carry out of the month advances the year, which wraps from 0x99 to 0x00.
- R5: The weekday (address 0x08, bits 2:0, binary) advances by one on every carry out of the hours. From 6 or above it returns to 0.
- R6: Bit 7 of the seconds byte is set by reset and by the reset command. A write to 0x04 with bit 7 at 0 clears it. A write with bit 7 at 1 leaves it unchanged, and no tick changes it.
- R7: While bit 5 of the control byte at 0x00 is 1, ticks do not advance the time and are discarded rather than held. During that time `presc_hold` is 1.
- R8: While `acc_busy` is 1, the time does not advance and reads return the frozen values. If one or more ticks arrive during that time, the time advances by exactly one second in the cycle after `acc_busy` falls.
- R9: Writing 0x58 to address 0x00 returns every register to its R1 value in the next cycle, with the seconds flag set. The code itself is not stored.
- R10: Address 0x03 (scratch) and address 0x01 store any byte written and return it on read. Such writes change no time register.
- R11: A time write stores only the meaningful bits: seconds and minutes bits 6:0, hours and day bits 5:0, weekday bits 2:0, month bits 4:0, year bits 7:0. The other bits read 0. Address 0x02 and every address above 0x0A read 0.
- R12: A time value holding a non-decimal digit is kept as written. On the next increment, a ones digit of 9 or above becomes 0 and carries into the tens digit. A value at or above the field's top value wraps to the field's lowest value and carries into the next field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe marking the end of a second |
| acc_busy | input | 1 | High for the whole of a multi-byte access; freezes the time |
| wr_en | input | 1 | Write strobe; writes `wdata` to `addr` at the clock edge |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| presc_hold | output | 1 | Holds the external prescaler cleared while halted |

## Verification
A write or a tick sampled at one rising edge is visible on `rdata` from that edge on. The bench therefore drives every stimulus at a falling edge and reads at the next falling edge, one full register stage later. A tick held back by `acc_busy` shows only one edge after `acc_busy` drops. The bench reads once before that edge, expecting the frozen value, and once after it, expecting exactly one added second. The sweeps cover a whole hour second by second, every day of a leap year and of a common year, and the year wrap from each of the 100 years. All expected values come from a binary model that the bench converts to BCD.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam logic [7:0] ADR_CTRL1 = 8'h00;
    localparam logic [7:0] ADR_CTRL2 = 8'h01;
    localparam logic [7:0] ADR_RAM   = 8'h03;
    localparam logic [7:0] ADR_SEC   = 8'h04;
    localparam logic [7:0] ADR_MIN   = 8'h05;
    localparam logic [7:0] ADR_HOUR  = 8'h06;
    localparam logic [7:0] ADR_DAY   = 8'h07;
    localparam logic [7:0] ADR_WDAY  = 8'h08;
    localparam logic [7:0] ADR_MON   = 8'h09;
    localparam logic [7:0] ADR_YEAR  = 8'h0A;

    typedef struct packed {
        logic       os;
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [5:0] day;
        logic [2:0] wday;
        logic [4:0] mon;
        logic [7:0] year;
    } rtc_time_t;

    typedef struct packed {
        logic [7:0] ctrl1;
        logic [7:0] ctrl2;
        logic [7:0] ram;
    } rtc_ctrl_t;

    localparam rtc_time_t TIME_RST = '{
        os: 1'b1, sec: 7'h00, min: 7'h00, hour: 6'h00,
        day: 6'h01, wday: 3'd0, mon: 5'h01, year: 8'h00
    };

    // One BCD increment: result[8] is the carry, result[7:0] the new value.
    function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] lo,
                                            input logic [7:0] hi);
        logic [8:0] r;
        if (v >= hi)
            r = {1'b1, lo};
        else if (v[3:0] >= 4'd9)
            r = {1'b0, v[7:4] + 4'd1, 4'd0};
        else
            r = {1'b0, v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // A BCD year is divisible by four when an even tens digit meets 0/4/8
    // or an odd tens digit meets 2/6.
    function automatic logic bcd_leap(input logic [7:0] y);
        logic r;
        if (y[4])
            r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        else
            r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        return r;
    endfunction

    function automatic logic [7:0] bcd_last_day(input logic [4:0] mon,
                                                input logic [7:0] year);
        logic [7:0] r;
        case (mon)
            5'h02:                      r = bcd_leap(year) ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_tick_gate.sv
module rtc_tick_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic freeze,
    input  logic stop,
    output logic adv,
    output logic pend
);
    logic pend_d, pend_q;

    always_comb begin
        adv    = !stop && !freeze && (tick || pend_q);
        pend_d = pend_q;
        if (clear || stop)
            pend_d = 1'b0;
        else if (freeze)
            pend_d = pend_q || tick;
        else
            pend_d = pend_q && tick;   // a second strobe landing with the release stays queued
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else
            pend_q <= pend_d;
    end

    assign pend = pend_q;
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
    import rtc_cal_pkg::*;
#(
    parameter logic [7:0] SWRST_CODE = 8'h58,
    parameter int         STOP_BIT   = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic       swr,
    output logic       stop,
    output rtc_ctrl_t  ctrl
);
    rtc_ctrl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        swr = 1'b0;
        if (wr_en) begin
            case (addr)
                ADR_CTRL1: begin
                    if (wdata == SWRST_CODE)
                        swr = 1'b1;
                    else
                        c_d.ctrl1 = wdata;
                end
                ADR_CTRL2: c_d.ctrl2 = wdata;
                ADR_RAM:   c_d.ram   = wdata;
                default:   ;
            endcase
        end
        if (swr)
            c_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            c_q <= '0;
        else
            c_q <= c_d;
    end

    assign stop = c_q.ctrl1[STOP_BIT];
    assign ctrl = c_q;
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_cal_pkg::*;
#(
    parameter int WDAY_LAST = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       adv,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output rtc_time_t  time_o
);
    localparam logic [2:0] WDAY_LIM = 3'(WDAY_LAST);

    rtc_time_t  t_d, t_q;
    logic [8:0] sec_s, min_s, hour_s, day_s, mon_s, year_s;

    always_comb begin
        sec_s  = bcd_step({1'b0, t_q.sec},  8'h00, 8'h59);
        min_s  = bcd_step({1'b0, t_q.min},  8'h00, 8'h59);
        hour_s = bcd_step({2'b0, t_q.hour}, 8'h00, 8'h23);
        day_s  = bcd_step({2'b0, t_q.day},  8'h01, bcd_last_day(t_q.mon, t_q.year));
        mon_s  = bcd_step({3'b0, t_q.mon},  8'h01, 8'h12);
        year_s = bcd_step(t_q.year,         8'h00, 8'h99);

        t_d = t_q;
        if (adv) begin
            t_d.sec = sec_s[6:0];
            if (sec_s[8]) begin
                t_d.min = min_s[6:0];
                if (min_s[8]) begin
                    t_d.hour = hour_s[5:0];
                    if (hour_s[8]) begin
                        t_d.day  = day_s[5:0];
                        t_d.wday = (t_q.wday >= WDAY_LIM) ? 3'd0 : t_q.wday + 3'd1;
                        if (day_s[8]) begin
                            t_d.mon = mon_s[4:0];
                            if (mon_s[8])
                                t_d.year = year_s[7:0];
                        end
                    end
                end
            end
        end

        if (wr_en) begin
            case (addr)
                ADR_SEC: begin
                    t_d.sec = wdata[6:0];
                    if (!wdata[7])
                        t_d.os = 1'b0;
                end
                ADR_MIN:  t_d.min  = wdata[6:0];
                ADR_HOUR: t_d.hour = wdata[5:0];
                ADR_DAY:  t_d.day  = wdata[5:0];
                ADR_WDAY: t_d.wday = wdata[2:0];
                ADR_MON:  t_d.mon  = wdata[4:0];
                ADR_YEAR: t_d.year = wdata;
                default:  ;
            endcase
        end

        if (clear)
            t_d = TIME_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            t_q <= TIME_RST;
        else
            t_q <= t_d;
    end

    assign time_o = t_q;
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter logic [7:0] SWRST_CODE = 8'h58,
    parameter int         STOP_BIT   = 5,
    parameter int         WDAY_LAST  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       acc_busy,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       presc_hold
);
    logic      swr, stop, adv, pend;
    rtc_ctrl_t ctrl;
    rtc_time_t time_q;

    rtc_ctrl_regs #(
        .SWRST_CODE (SWRST_CODE),
        .STOP_BIT   (STOP_BIT)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .swr   (swr),
        .stop  (stop),
        .ctrl  (ctrl)
    );

    rtc_tick_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (swr),
        .tick   (sec_tick),
        .freeze (acc_busy),
        .stop   (stop),
        .adv    (adv),
        .pend   (pend)
    );

    rtc_time_chain #(
        .WDAY_LAST (WDAY_LAST)
    ) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (swr),
        .adv    (adv),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .time_o (time_q)
    );

    always_comb begin
        case (addr)
            ADR_CTRL1: rdata = ctrl.ctrl1;
            ADR_CTRL2: rdata = ctrl.ctrl2;
            ADR_RAM:   rdata = ctrl.ram;
            ADR_SEC:   rdata = {time_q.os, time_q.sec};
            ADR_MIN:   rdata = {1'b0, time_q.min};
            ADR_HOUR:  rdata = {2'b0, time_q.hour};
            ADR_DAY:   rdata = {2'b0, time_q.day};
            ADR_WDAY:  rdata = {5'b0, time_q.wday};
            ADR_MON:   rdata = {3'b0, time_q.mon};
            ADR_YEAR:  rdata = time_q.year;
            default:   rdata = 8'h00;
        endcase
    end

    assign presc_hold = stop;
endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk #(
    parameter int WDAY_LAST = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       swr,
    input logic       wr_en,
    input logic       acc_busy,
    input logic       stop,
    input logic       os,
    input logic [6:0] sec,
    input logic [2:0] wday,
    input logic [7:0] ctrl1,
    input logic [7:0] ram
);
    localparam logic [2:0] WDAY_LIM = 3'(WDAY_LAST);

    // R8
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_busy && !wr_en) |=> $stable(sec));

    // R7
    halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !wr_en) |=> $stable(sec));

    // R6
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(os) |-> $past(swr));

    // R9
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swr |=> (os && ctrl1 == 8'h00 && ram == 8'h00));

    // R2
    sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec <= 7'h59 && !wr_en) |=> (sec <= 7'h59));

    // R5
    wday_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wday <= WDAY_LIM && !wr_en) |=> (wday <= WDAY_LIM));
endmodule

bind rtc_calendar_core rtc_calendar_core_chk #(.WDAY_LAST(WDAY_LAST)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .swr      (swr),
    .wr_en    (wr_en),
    .acc_busy (acc_busy),
    .stop     (stop),
    .os       (time_q.os),
    .sec      (time_q.sec),
    .wday     (time_q.wday),
    .ctrl1    (ctrl.ctrl1),
    .ram      (ctrl.ram)
);

// File: tb/rtc_calendar_core_test.sv
module rtc_calendar_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       acc_busy = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       presc_hold;

    int n_chk = 0;
    int n_bad = 0;

    rtc_calendar_core uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_tick   (sec_tick),
        .acc_busy   (acc_busy),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .presc_hold (presc_hold)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dim(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic rchk(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic set_hms(input int h, input int m, input int s);
        wr(8'h06, bcd(h));
        wr(8'h05, bcd(m));
        wr(8'h04, bcd(s));
    endtask

    task automatic set_date(input int d, input int w, input int m, input int y);
        wr(8'h07, bcd(d));
        wr(8'h08, 8'(w));
        wr(8'h09, bcd(m));
        wr(8'h0A, bcd(y));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int s, m, h, dd, mo, yy, wd;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rchk("R1 sec",   8'h04, 8'h80);
        rchk("R1 min",   8'h05, 8'h00);
        rchk("R1 hour",  8'h06, 8'h00);
        rchk("R1 day",   8'h07, 8'h01);
        rchk("R1 wday",  8'h08, 8'h00);
        rchk("R1 mon",   8'h09, 8'h01);
        rchk("R1 year",  8'h0A, 8'h00);
        rchk("R1 ctrl1", 8'h00, 8'h00);
        rchk("R1 ctrl2", 8'h01, 8'h00);
        rchk("R1 ram",   8'h03, 8'h00);
        chk("R1 presc_hold", {7'b0, presc_hold}, 8'h00);

        // R6 flag is kept by ticks, cleared by a write with bit 7 low
        tick();
        rchk("R6 flag kept over tick", 8'h04, 8'h81);
        wr(8'h04, 8'h85);
        rchk("R6 write with bit7 high keeps flag", 8'h04, 8'h85);
        wr(8'h04, 8'h00);
        rchk("R6 cleared", 8'h04, 8'h00);
        wr(8'h04, 8'h97);
        rchk("R6 cannot be set by write", 8'h04, 8'h17);

        // R10 scratch and second control byte
        for (int i = 0; i < 256; i += 37) begin
            wr(8'h03, 8'(i));
            rchk("R10 ram", 8'h03, 8'(i));
            wr(8'h01, 8'(255 - i));
            rchk("R10 ctrl2", 8'h01, 8'(255 - i));
        end
        rchk("R10 time untouched", 8'h04, 8'h17);

        // R2 one full hour plus a minute, second by second
        set_hms(0, 0, 0);
        s = 0; m = 0; h = 0;
        for (int i = 0; i < 3661; i++) begin
            tick();
            s++;
            if (s == 60) begin s = 0; m++; end
            if (m == 60) begin m = 0; h++; end
            rchk("R2 sec", 8'h04, bcd(s));
            rchk("R2 min", 8'h05, bcd(m));
            rchk("R2 hour", 8'h06, bcd(h));
        end
        set_hms(23, 59, 58);
        tick(); tick();
        rchk("R2 hour wrap", 8'h06, 8'h00);

        // R3 R5 every day of a leap year and a common year
        for (int pass = 0; pass < 2; pass++) begin
            yy = (pass == 0) ? 0 : 23; dd = 1; mo = 1; wd = 3;
            set_date(dd, wd, mo, yy);
            for (int k = 0; k < 366; k++) begin
                set_hms(23, 59, 59);
                tick();
                dd++; wd = (wd >= 6) ? 0 : wd + 1;
                if (dd > dim(mo, yy)) begin dd = 1; mo++; end
                if (mo > 12) begin mo = 1; yy = (yy + 1) % 100; end
                rchk("R3 day", 8'h07, bcd(dd));
                rchk("R4 mon", 8'h09, bcd(mo));
                rchk("R5 wday", 8'h08, 8'(wd));
                rchk("R2 sec after day", 8'h04, 8'h00);
                if (dd == 1 && mo == 1) break;
            end
            rchk("R4 year", 8'h0A, bcd(yy));
        end

        // R3 February end for every year of the range
        for (int y = 0; y < 100; y++) begin
            set_date(28, 0, 2, y);
            set_hms(23, 59, 59);
            tick();
            rchk("R3 feb", 8'h07, (y % 4 == 0) ? 8'h29 : 8'h01);
        end

        // R4 year wrap from every year
        for (int y = 0; y < 100; y++) begin
            set_date(31, 6, 12, y);
            set_hms(23, 59, 59);
            tick();
            rchk("R4 year next", 8'h0A, bcd((y + 1) % 100));
            rchk("R4 mon wrap", 8'h09, 8'h01);
            rchk("R5 wday wrap", 8'h08, 8'h00);
        end

        // R11 masking and unmapped addresses
        wr(8'h06, 8'hFF); rchk("R11 hour mask", 8'h06, 8'h3F);
        wr(8'h07, 8'hFF); rchk("R11 day mask",  8'h07, 8'h3F);
        wr(8'h08, 8'hFF); rchk("R11 wday mask", 8'h08, 8'h07);
        wr(8'h09, 8'hFF); rchk("R11 mon mask",  8'h09, 8'h1F);
        wr(8'h05, 8'hFF); rchk("R11 min mask",  8'h05, 8'h7F);
        wr(8'h02, 8'hAA); rchk("R11 addr 02",   8'h02, 8'h00);
        wr(8'h0B, 8'hAA); rchk("R11 addr 0B",   8'h0B, 8'h00);
        rchk("R11 addr FF", 8'hFF, 8'h00);

        // R12 non-decimal digits
        set_date(1, 0, 1, 0);
        set_hms(5, 10, 0);
        wr(8'h04, 8'h4A); rchk("R12 stored", 8'h04, 8'h4A);
        tick(); rchk("R12 digit carry", 8'h04, 8'h50);
        wr(8'h04, 8'h7F); tick();
        rchk("R12 over top wraps", 8'h04, 8'h00);
        rchk("R12 carry to min", 8'h05, 8'h11);
        wr(8'h05, 8'h3C); wr(8'h04, 8'h59); tick();
        rchk("R12 min digit", 8'h05, 8'h40);

        // R7 halt
        set_hms(1, 2, 3);
        wr(8'h00, 8'h20);
        chk("R7 presc_hold", {7'b0, presc_hold}, 8'h01);
        tick(); tick();
        rchk("R7 halted", 8'h04, 8'h03);
        wr(8'h00, 8'h00);
        rchk("R7 ticks discarded", 8'h04, 8'h03);
        chk("R7 presc_hold off", {7'b0, presc_hold}, 8'h00);
        tick();
        rchk("R7 runs again", 8'h04, 8'h04);

        // R8 freeze with two ticks pending
        @(negedge clk); acc_busy = 1'b1;
        tick(); tick();
        rchk("R8 frozen", 8'h04, 8'h04);
        @(negedge clk); acc_busy = 1'b0;
        #1 chk("R8 not before edge", rdata, 8'h04);
        rchk("R8 released once", 8'h04, 8'h05);
        rchk("R8 single", 8'h04, 8'h05);
        // R8 no ticks during freeze
        @(negedge clk); acc_busy = 1'b1;
        repeat (3) @(negedge clk);
        acc_busy = 1'b0;
        rchk("R8 no pending", 8'h04, 8'h05);
        rchk("R8 no pending later", 8'h04, 8'h05);

        // R9 software reset
        wr(8'h03, 8'h5A);
        wr(8'h00, 8'h21);
        wr(8'h00, 8'h58);
        rchk("R9 ctrl1", 8'h00, 8'h00);
        rchk("R9 ram", 8'h03, 8'h00);
        rchk("R9 sec flag", 8'h04, 8'h80);
        rchk("R9 min", 8'h05, 8'h00);
        rchk("R9 day", 8'h07, 8'h01);
        rchk("R9 mon", 8'h09, 8'h01);
        rchk("R9 year", 8'h0A, 8'h00);
        chk("R9 presc_hold", {7'b0, presc_hold}, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule